// File: doc/BRIEF.md
# Port Blocking Rate Monitor

This block sits beside a processing core and watches the handshake outcome of the core's input port and of its output port every cycle. Each side has a saturating up/down counter. A transfer that is attempted but blocked raises the count, and a transfer that completes lowers it. A side whose count climbs to a programmable threshold is congested. Congestion on the input side means that upstream producers are waiting on the core, so the block requests a faster core clock. Congestion on the output side means that downstream consumers cannot keep pace, so the block requests a slower one.

The requests are single-cycle pulses sent to a separate clock-selection and configuration unit. This block does not touch the clock or the supply itself. After it issues a request, both counters are held at zero for a programmable number of cycles so that the clock change can settle before congestion is measured again. If both sides reach the threshold together, the evidence conflicts: no request is issued, and both counters start over.

Top module: `port_block_monitor`

## Requirements
- R1: On a side with an attempt, a blocked transfer (attempt=1, success=0) adds one to that side's count and a completed transfer (attempt=1, success=1) subtracts one. When the count, as registered after a clock edge, is at or above a non-zero threshold, the request pulse appears after the next clock edge.
- R2: When the input-side count reaches the threshold and the output side does not, `speed_up_o` pulses high for one cycle.
- R3: When the output-side count reaches the threshold and the input side does not, `slow_down_o` pulses high for one cycle.
- R4: A completed transfer at count zero leaves the count at zero.
- R5: A blocked transfer at count 2^CNT_W-1 (63 with the default parameters) leaves the count at that value. It does not wrap.
- R6: In a cycle with attempt=0, the count of that side does not change, whatever the success input carries.
- R7: Issuing a request clears both counters in the same edge. Each pulse lasts exactly one cycle, and the two outputs are never high together.
- R8: If both counts are at or above the threshold in the same cycle, neither output pulses, both counters clear, and no hold-off period starts.
- R9: After a request, both counters stay at zero and ignore all transfers for `hold_len_i` cycles. Counting resumes on the following cycle. A hold length of zero means counting resumes at once.
- R10: A threshold of zero disables both requests. If the threshold is lowered to a value at or below a count that is already held, the request fires on the next edge.
- R11: While `rst_n` is low, both outputs are low and both counts are zero. The internal reset is released through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_try_i | input | 1 | Input port attempted a transfer this cycle |
| in_ok_i | input | 1 | Input port transfer completed (valid with in_try_i) |
| out_try_i | input | 1 | Output port attempted a transfer this cycle |
| out_ok_i | input | 1 | Output port transfer completed (valid with out_try_i) |
| thresh_i | input | CNT_W | Congestion threshold; zero disables requests |
| hold_len_i | input | HOLD_W | Settle period in cycles after a request |
| speed_up_o | output | 1 | One-cycle request for a faster core clock |
| slow_down_o | output | 1 | One-cycle request for a slower core clock |

## Verification
The upper saturation point is the hardest case to reach, because the counts are visible only through the request pulses, and a request normally clears the count long before the ceiling. The stimulus disables requests by setting the threshold to zero and drives more blocked cycles than the counter can hold. It then removes one count with a completed transfer and raises the threshold to the maximum. A pulse that arrives only after exactly one further blocked cycle shows that the count saturated rather than wrapped. The same approach, a simultaneous threshold crossing followed by immediate recounting, exposes the conflict path and shows that no hold-off started there.

// File: rtl/bpm_pkg.sv
package bpm_pkg;
  localparam int NUM_SIDES = 2;
  localparam int SIDE_IN   = 0;
  localparam int SIDE_OUT  = 1;

  typedef struct packed {
    logic attempt;
    logic success;
  } xfer_t;
endpackage

// File: rtl/bpm_port_counter.sv
module bpm_port_counter
  import bpm_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  xfer_t            xfer,
  input  logic             clr,
  input  logic [CNT_W-1:0] thresh,
  output logic             hit
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (xfer.attempt) begin
      if (xfer.success) begin
        if (cnt_q != '0) cnt_d = cnt_q - ONE;
      end else begin
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + ONE;
      end
    end
  end

  assign cnt_en = clr | xfer.attempt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign hit = (thresh != '0) && (cnt_q >= thresh);

  assert_sat_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && xfer.attempt && !xfer.success && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
  assert_sat_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && xfer.attempt && xfer.success && cnt_q == '0) |=> (cnt_q == '0));
  assert_idle_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !xfer.attempt) |=> $stable(cnt_q));
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/bpm_holdoff.sv
module bpm_holdoff #(
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [HOLD_W-1:0] len,
  output logic              active
);
  localparam logic [HOLD_W-1:0] ONE = HOLD_W'(1);

  logic [HOLD_W-1:0] hold_q, hold_d;
  logic              hold_en;

  always_comb begin
    hold_d = hold_q;
    if (start)              hold_d = len;
    else if (hold_q != '0)  hold_d = hold_q - ONE;
  end

  assign hold_en = start | (hold_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= hold_d;
  end

  assign active = (hold_q != '0);

  assert_hold_countdown_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !start) |=> (hold_q == $past(hold_q) - ONE));
  assert_hold_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (hold_q == $past(len)));
endmodule

// File: rtl/port_block_monitor.sv
module port_block_monitor
  import bpm_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_try_i,
  input  logic              in_ok_i,
  input  logic              out_try_i,
  input  logic              out_ok_i,
  input  logic [CNT_W-1:0]  thresh_i,
  input  logic [HOLD_W-1:0] hold_len_i,
  output logic              speed_up_o,
  output logic              slow_down_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  xfer_t [NUM_SIDES-1:0] xfers;
  logic  [NUM_SIDES-1:0] hits;
  logic                  fire_up, fire_dn, conflict, hold_active, clr_all;

  assign xfers[SIDE_IN]  = '{attempt: in_try_i,  success: in_ok_i};
  assign xfers[SIDE_OUT] = '{attempt: out_try_i, success: out_ok_i};

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    bpm_port_counter #(.CNT_W(CNT_W)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .xfer   (xfers[s]),
      .clr    (clr_all),
      .thresh (thresh_i),
      .hit    (hits[s])
    );
  end

  assign conflict = hits[SIDE_IN] & hits[SIDE_OUT];
  assign fire_up  = hits[SIDE_IN]  & ~hits[SIDE_OUT];
  assign fire_dn  = hits[SIDE_OUT] & ~hits[SIDE_IN];
  assign clr_all  = fire_up | fire_dn | conflict | hold_active;

  bpm_holdoff #(.HOLD_W(HOLD_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .start  (fire_up | fire_dn),
    .len    (hold_len_i),
    .active (hold_active)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      speed_up_o  <= 1'b0;
      slow_down_o <= 1'b0;
    end else begin
      speed_up_o  <= fire_up;
      slow_down_o <= fire_dn;
    end
  end

  assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(speed_up_o && slow_down_o));
  assert_up_single_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    speed_up_o |=> !speed_up_o);
  assert_dn_single_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    slow_down_o |=> !slow_down_o);
  assert_quiet_in_hold_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    hold_active |=> !(speed_up_o || slow_down_o));
  assert_conflict_silent_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    conflict |=> !(speed_up_o || slow_down_o));
  assert_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (thresh_i == '0) |=> !(speed_up_o || slow_down_o));
endmodule

// File: tb/sim_port_block_monitor.sv
module sim_port_block_monitor;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_try, in_ok, out_try, out_ok;
  logic [5:0] thresh;
  logic [7:0] hold_len;
  logic       speed_up, slow_down;
  int         checks = 0;
  int         fails  = 0;
  bit         done   = 0;

  always #4 clk = ~clk;

  port_block_monitor u0 (
    .clk(clk), .rst_n(rst_n),
    .in_try_i(in_try), .in_ok_i(in_ok),
    .out_try_i(out_try), .out_ok_i(out_ok),
    .thresh_i(thresh), .hold_len_i(hold_len),
    .speed_up_o(speed_up), .slow_down_o(slow_down)
  );

  task automatic check(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // drive one cycle's inputs, return at the following falling edge
  task automatic cyc(input logic ia, input logic io, input logic oa, input logic oo);
    in_try = ia; in_ok = io; out_try = oa; out_ok = oo;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; thresh = 6'd3; hold_len = 8'd0;
    in_try = 0; in_ok = 0; out_try = 0; out_ok = 0;
    repeat (3) @(negedge clk);
    check(speed_up, 1'b0, "R11", "speed_up in reset");
    check(slow_down, 1'b0, "R11", "slow_down in reset");
    rst_n = 1'b1;
    idle(4);
  endtask

  task automatic t_count_in;   // R1 R2
    cyc(1, 0, 0, 0); cyc(1, 0, 0, 0); cyc(1, 1, 0, 0);  // 1
    cyc(1, 0, 0, 0);                                    // 2
    cyc(0, 0, 0, 0);
    check(speed_up, 1'b0, "R1", "below threshold after decrement");
    cyc(1, 0, 0, 0);                                    // 3
    check(speed_up, 1'b0, "R1", "pulse not before next edge");
    cyc(0, 0, 0, 0);
    check(speed_up, 1'b1, "R2", "input congestion requests speed up");
    check(slow_down, 1'b0, "R2", "no slow down on input congestion");
    cyc(0, 0, 0, 0);
    check(speed_up, 1'b0, "R7", "pulse lasts one cycle");
  endtask

  task automatic t_out;        // R3
    repeat (3) cyc(0, 0, 1, 0);
    cyc(0, 0, 0, 0);
    check(slow_down, 1'b1, "R3", "output congestion requests slow down");
    check(speed_up, 1'b0, "R3", "no speed up on output congestion");
    idle(1);
  endtask

  task automatic t_floor;      // R4
    repeat (3) cyc(1, 1, 0, 0);
    cyc(1, 0, 0, 0); cyc(1, 0, 0, 0); cyc(0, 0, 0, 0);
    check(speed_up, 1'b0, "R4", "two blocks after floor");
    cyc(1, 0, 0, 0); cyc(0, 0, 0, 0);
    check(speed_up, 1'b1, "R4", "count floored at zero");
    idle(1);
  endtask

  task automatic t_idle;       // R6
    cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
    for (int i = 0; i < 5; i++) cyc(0, 1, 0, 1);
    check(speed_up, 1'b0, "R6", "no pulse while idle");
    cyc(1, 0, 0, 0); cyc(0, 0, 0, 0);
    check(speed_up, 1'b1, "R6", "success without attempt ignored");
    idle(1);
  endtask

  task automatic t_clear;      // R7
    cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
    repeat (3) cyc(0, 0, 1, 0);
    cyc(0, 0, 0, 0);
    check(slow_down, 1'b1, "R7", "output side fires");
    cyc(1, 0, 0, 0); cyc(0, 0, 0, 0);
    check(speed_up, 1'b0, "R7", "input count cleared by other side");
    cyc(1, 0, 0, 0); cyc(1, 0, 0, 0); cyc(0, 0, 0, 0);
    check(speed_up, 1'b1, "R7", "input recounts from zero");
    idle(1);
  endtask

  task automatic t_both;       // R8
    thresh = 6'd2; hold_len = 8'd4;
    cyc(1, 0, 1, 0); cyc(1, 0, 1, 0); cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
    check(speed_up, 1'b0, "R8", "no speed up on conflict");
    check(slow_down, 1'b0, "R8", "no slow down on conflict");
    cyc(1, 0, 0, 0); cyc(1, 0, 0, 0); cyc(0, 0, 0, 0);
    check(speed_up, 1'b1, "R8", "cleared, no hold-off after conflict");
    idle(6);
  endtask

  task automatic t_hold;       // R9
    thresh = 6'd1; hold_len = 8'd4;
    cyc(1, 0, 0, 0); cyc(0, 0, 0, 0);
    check(speed_up, 1'b1, "R9", "trigger starting hold-off");
    repeat (4) cyc(1, 0, 0, 0);
    cyc(0, 0, 0, 0);
    check(speed_up, 1'b0, "R9", "blocks ignored during hold-off");
    cyc(1, 0, 0, 0); cyc(0, 0, 0, 0);
    check(speed_up, 1'b1, "R9", "counting resumes after hold-off");
    hold_len = 8'd0;
    idle(6);
  endtask

  task automatic t_ceiling;    // R5 R10
    int seen = 0;
    thresh = 6'd0;
    for (int i = 0; i < 70; i++) begin
      cyc(1, 0, 0, 0);
      if (speed_up) seen++;
    end
    check(seen != 0, 1'b0, "R10", "zero threshold disables");
    cyc(1, 1, 0, 0);                              // 63 -> 62
    thresh = 6'd63;
    cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    check(speed_up, 1'b0, "R5", "count one below ceiling");
    cyc(1, 0, 0, 0); cyc(0, 0, 0, 0);
    check(speed_up, 1'b1, "R5", "count saturated at 63");
    idle(1);
    thresh = 6'd0;
    repeat (5) cyc(1, 0, 0, 0);
    thresh = 6'd3;
    cyc(0, 0, 0, 0);
    check(speed_up, 1'b1, "R10", "lowered threshold fires at once");
    idle(2);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_count_in();
    t_out();
    t_floor();
    t_idle();
    t_clear();
    t_both();
    t_hold();
    t_ceiling();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule